// File: doc/BRIEF.md
# ADC Step Sequencer

The block runs a programmable list of up to sixteen conversion steps against an external converter. Each step has a configuration word and a delay word, and one bit in an enable mask. On a software start, the sequencer visits the enabled steps in ascending index order. For each step it waits an open delay. It then takes a power-of-two number of samples, waiting a sample delay before each conversion request. It averages the returned 12-bit codes and writes one tagged result into one of two result FIFOs.

A step can be one-shot, continuous, or held until a rising edge on a hardware trigger input. Passes repeat for as long as any step remains enabled. A sticky end-of-pass flag, a busy line and per-FIFO sticky overrun flags report progress. Software programs the block through a simple write port. It clears the flags by writing ones to a flag address.

Top module: `adc_step_seq`

## Requirements
- R1: After reset `busy_o`, `eos_o`, `ovr_o` and `step_en_o` are zero, and no FIFO write or conversion request is issued.
- R2: Enabled steps are processed in ascending index order and disabled steps are skipped. Each pushed word carries the 12-bit result in bits 11:0 and the 4-bit step index in bits 19:16, with all other bits zero.
- R3: The configuration field at bits 4:2 (value a) makes a step issue exactly 2^a conversion requests. The pushed result is the sum of the returned codes shifted right by a.
- R4: In the delay word, bits 17:0 hold the open delay O and bits 31:24 hold the sample delay S. At least O+S cycles pass from start to a step's first request, and at least S cycles pass between a converter response and the next request. `conv_req_o` is a one-cycle pulse.
- R5: Configuration bit 26 routes the step's result to FIFO 1 when set and to FIFO 0 when clear. Only one FIFO is written per result.
- R6: Configuration bits 1:0 select the mode. Mode 0 is one-shot: the step's enable bit clears when its result is pushed. Mode 1 is continuous: the bit stays set and passes repeat until software clears it.
- R7: A mode 2 step starts its open delay only after a rising edge of `trig_i`. Clearing that step's enable bit while it waits releases the sequencer.
- R8: `eos_o` is set at the end of every pass and stays set until cleared. `busy_o` is high from an accepted start until the sequencer returns to idle.
- R9: A result aimed at a full FIFO is dropped and sets that FIFO's sticky overrun bit in `ovr_o`.
- R10: A start with an all-zero enable mask is ignored: `busy_o` stays low and no flag changes.
- R11: The write map is as follows. Addresses 0–15 hold the step configurations and 16–31 the delay words. Address 32 holds the enable mask. Address 33 is write-one-to-clear, with bit 0 for `eos_o`, bit 1 for FIFO 0 overrun and bit 2 for FIFO 1 overrun. Writing configuration or delay words does not change the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (converter clock domain) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| start_i | input | 1 | Software start pulse |
| trig_i | input | 1 | Hardware trigger level |
| conv_req_o | output | 1 | Conversion request pulse |
| conv_valid_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result code |
| fifo0_we_o | output | 1 | FIFO 0 write enable |
| fifo1_we_o | output | 1 | FIFO 1 write enable |
| fifo_data_o | output | 32 | Tagged result word |
| fifo0_full_i | input | 1 | FIFO 0 full |
| fifo1_full_i | input | 1 | FIFO 1 full |
| step_en_o | output | 16 | Live step enable mask |
| eos_o | output | 1 | Sticky end-of-pass flag |
| busy_o | output | 1 | Sequencer active |
| ovr_o | output | 2 | Sticky overrun flags, bit k for FIFO k |

## Verification
The bench sweeps random enable masks that contain step 0 and step 15, so a design that drops the last index or restarts from the wrong position shows up as missing or reordered tags. Averaging fields from 0 to 2 are compared against the bench's own sum of the codes it returned. An off-by-one sample count shows up as a wrong request count or a wrong shifted value. A trigger-held step is checked for not starting before its edge, and for letting the sequencer go idle once disabled. A design that waits forever would hang that test. A full FIFO must swallow the write, and a design that still strobes it or forgets the overrun bit fails the drop check.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W     = 12;
  localparam int AVG_W     = 3;
  localparam int MODE_LO   = 0;
  localparam int AVG_LO    = 2;
  localparam int FSEL_BIT  = 26;
  localparam int OPEN_W    = 18;
  localparam int SDLY_LO   = 24;
  localparam int SDLY_W    = 8;
  localparam int TAG_LO    = 16;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_CONT = 2'd1,
    MODE_TRIG = 2'd2
  } step_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_TRIG, S_OPEN, S_SDLY, S_REQ, S_WAIT, S_PUSH
  } seq_state_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
  parameter int N_STEPS = 16,
  parameter int AW      = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [N_STEPS-1:0]      clr_mask_i,
  output logic [N_STEPS-1:0][31:0] cfg_o,
  output logic [N_STEPS-1:0][31:0] dly_o,
  output logic [N_STEPS-1:0]      en_o
);
  localparam int DLY_BASE = N_STEPS;
  localparam int EN_ADDR  = 2 * N_STEPS;

  logic [N_STEPS-1:0] en_q;

  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g] <= '0;
        dly_o[g] <= '0;
      end else if (we_i) begin
        if (addr_i == AW'(g))            cfg_o[g] <= wdata_i;
        if (addr_i == AW'(DLY_BASE + g)) dly_o[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else en_q <= ((we_i && addr_i == AW'(EN_ADDR)) ? wdata_i[N_STEPS-1:0] : en_q) & ~clr_mask_i;
  end

  assign en_o = en_q;

  // a completed one-shot step must not stay enabled
  p_oneshot_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask_i != '0) |=> ((en_q & $past(clr_mask_i)) == '0));
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int N_STEPS = 16,
  parameter int SW      = $clog2(N_STEPS),
  parameter int FW      = SW + 1
) (
  input  logic [N_STEPS-1:0] mask_i,
  input  logic [FW-1:0]      from_i,
  output logic               found_o,
  output logic [SW-1:0]      idx_o
);
  // lowest enabled index at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_STEPS - 1; i >= 0; i--) begin
      if (mask_i[i] && FW'(i) >= from_i) begin
        found_o = 1'b1;
        idx_o   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg
  import adc_seq_pkg::*;
#(
  parameter int DW = RES_W,
  parameter int SH = AVG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] data_i,
  input  logic [SH-1:0] shift_i,
  output logic [DW-1:0] result_o
);
  localparam int ACC_W = DW + (2 ** SH) - 1;

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= acc_q + ACC_W'(data_i);
  end

  assign result_o = DW'(acc_q >> shift_i);

  p_no_add_on_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && add_i));
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int AW      = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic               start_i,
  input  logic               trig_i,
  output logic               conv_req_o,
  input  logic               conv_valid_i,
  input  logic [RES_W-1:0]   conv_data_i,
  output logic               fifo0_we_o,
  output logic               fifo1_we_o,
  output logic [31:0]        fifo_data_o,
  input  logic               fifo0_full_i,
  input  logic               fifo1_full_i,
  output logic [N_STEPS-1:0] step_en_o,
  output logic               eos_o,
  output logic               busy_o,
  output logic [1:0]         ovr_o
);
  localparam int SW        = $clog2(N_STEPS);
  localparam int FW        = SW + 1;
  localparam int SMP_W     = (2 ** AVG_W) - 1;
  localparam int FLAG_ADDR = 2 * N_STEPS + 1;

  seq_state_e state_q;
  logic [SW-1:0]     cur_q;
  logic [FW-1:0]     from_q;
  logic [OPEN_W-1:0] cnt_q;
  logic [SMP_W-1:0]  smp_q;
  logic              trig_q, eos_q;
  logic [1:0]        ovr_q;

  logic [N_STEPS-1:0][31:0] cfg_w, dly_w;
  logic [N_STEPS-1:0] en_w, clr_mask;
  logic               found;
  logic [SW-1:0]      pick_idx;
  logic [RES_W-1:0]   avg_res;

  logic [31:0] cur_cfg, cur_dly, pick_cfg, pick_dly;
  step_mode_e  cur_mode, pick_mode;
  logic [AVG_W-1:0]  cur_avg;
  logic [OPEN_W-1:0] cur_sdly;
  logic [SMP_W-1:0]  smp_last;
  logic cur_sel, trig_rise, flag_wr, eos_set;
  logic [1:0] ovr_set;
  logic unused_cfg;

  assign cur_cfg   = cfg_w[cur_q];
  assign cur_dly   = dly_w[cur_q];
  assign pick_cfg  = cfg_w[pick_idx];
  assign pick_dly  = dly_w[pick_idx];
  assign cur_mode  = step_mode_e'(cur_cfg[MODE_LO +: 2]);
  assign pick_mode = step_mode_e'(pick_cfg[MODE_LO +: 2]);
  assign cur_avg   = cur_cfg[AVG_LO +: AVG_W];
  assign cur_sel   = cur_cfg[FSEL_BIT];
  assign cur_sdly  = OPEN_W'(cur_dly[SDLY_LO +: SDLY_W]);
  assign smp_last  = ~({SMP_W{1'b1}} << cur_avg);
  assign trig_rise = trig_i && !trig_q;
  assign flag_wr   = cfg_we_i && cfg_addr_i == AW'(FLAG_ADDR);
  assign unused_cfg = ^{cfg_w, dly_w, pick_dly};

  assign clr_mask = (state_q == S_PUSH && cur_mode == MODE_ONCE)
                    ? (N_STEPS'(1) << cur_q) : '0;

  adc_seq_regs #(.N_STEPS(N_STEPS), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .clr_mask_i(clr_mask), .cfg_o(cfg_w), .dly_o(dly_w), .en_o(en_w)
  );

  adc_seq_pick #(.N_STEPS(N_STEPS)) u_pick (
    .mask_i(en_w), .from_i(from_q), .found_o(found), .idx_o(pick_idx)
  );

  adc_seq_avg u_avg (
    .clk_i, .rst_ni,
    .clr_i(state_q == S_SCAN),
    .add_i(state_q == S_WAIT && conv_valid_i),
    .data_i(conv_data_i), .shift_i(cur_avg), .result_o(avg_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      from_q  <= '0;
      cnt_q   <= '0;
      smp_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      unique case (state_q)
        S_IDLE: if (start_i && |en_w) begin
          state_q <= S_SCAN;
          from_q  <= '0;
        end
        S_SCAN: if (found) begin
          cur_q   <= pick_idx;
          cnt_q   <= pick_dly[OPEN_W-1:0];
          smp_q   <= '0;
          state_q <= (pick_mode == MODE_TRIG) ? S_TRIG : S_OPEN;
        end else begin
          from_q  <= '0;
          state_q <= |en_w ? S_SCAN : S_IDLE;
        end
        S_TRIG: if (!en_w[cur_q]) begin
          from_q  <= {1'b0, cur_q} + FW'(1);
          state_q <= S_SCAN;
        end else if (trig_rise) state_q <= S_OPEN;
        S_OPEN: if (cnt_q == '0) begin
          cnt_q   <= cur_sdly;
          state_q <= S_SDLY;
        end else cnt_q <= cnt_q - 1'b1;
        S_SDLY: if (cnt_q == '0) state_q <= S_REQ;
                else cnt_q <= cnt_q - 1'b1;
        S_REQ:  state_q <= S_WAIT;
        S_WAIT: if (conv_valid_i) begin
          if (smp_q == smp_last) state_q <= S_PUSH;
          else begin
            smp_q   <= smp_q + 1'b1;
            cnt_q   <= cur_sdly;
            state_q <= S_SDLY;
          end
        end
        S_PUSH: begin
          from_q  <= {1'b0, cur_q} + FW'(1);
          state_q <= S_SCAN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign eos_set    = state_q == S_SCAN && !found;
  assign ovr_set[0] = state_q == S_PUSH && !cur_sel && fifo0_full_i;
  assign ovr_set[1] = state_q == S_PUSH &&  cur_sel && fifo1_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eos_q <= 1'b0;
      ovr_q <= '0;
    end else begin
      eos_q <= (eos_q & ~(flag_wr & cfg_wdata_i[0])) | eos_set;
      ovr_q <= (ovr_q & ~({2{flag_wr}} & cfg_wdata_i[2:1])) | ovr_set;
    end
  end

  always_comb begin
    fifo_data_o = '0;
    fifo_data_o[TAG_LO +: SW]   = cur_q;
    fifo_data_o[RES_W-1:0]      = avg_res;
  end

  assign fifo0_we_o = state_q == S_PUSH && !cur_sel && !fifo0_full_i;
  assign fifo1_we_o = state_q == S_PUSH &&  cur_sel && !fifo1_full_i;
  assign conv_req_o = state_q == S_REQ;
  assign busy_o     = state_q != S_IDLE;
  assign eos_o      = eos_q;
  assign ovr_o      = ovr_q;
  assign step_en_o  = en_w;

  p_one_fifo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo0_we_o && fifo1_we_o));
  p_drop_full0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo0_we_o |-> !fifo0_full_i);
  p_drop_full1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo1_we_o |-> !fifo1_full_i);
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q[1] && !(flag_wr && cfg_wdata_i[2])) |=> ovr_q[1]);
  p_req_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  p_req_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy_o);
  p_eos_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_q && !(flag_wr && cfg_wdata_i[0])) |=> eos_q);
endmodule

// File: tb/sim_adc_step_seq.sv
module sim_adc_step_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, start = 1'b0, trig = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic conv_valid = 1'b0, full0 = 1'b0, full1 = 1'b0;
  logic [11:0] conv_data = '0;
  logic conv_req, we0, we1, eos, busy;
  logic [31:0] fdata;
  logic [15:0] step_en;
  logic [1:0] ovr;

  int total = 0, bad = 0, cyc = 0, pend = 0;
  int log_n = 0, sum = 0, cnt = 0;
  logic [31:0] log_data[256];
  logic        log_sel[256];
  int          log_sum[256], log_cnt[256];
  int first_req = -1, last_valid = 0, min_gap = 1000000;
  logic [2:0] b_avg[16];
  logic       b_sel[16];

  always #10 clk = ~clk;

  adc_step_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .start_i(start), .trig_i(trig), .conv_req_o(conv_req), .conv_valid_i(conv_valid),
    .conv_data_i(conv_data), .fifo0_we_o(we0), .fifo1_we_o(we1), .fifo_data_o(fdata),
    .fifo0_full_i(full0), .fifo1_full_i(full1), .step_en_o(step_en), .eos_o(eos),
    .busy_o(busy), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // converter model and FIFO monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (we0 && we1) chk(0, "R5 both FIFOs written", 32'd1, 32'd0);
    if ((we0 || we1) && log_n < 256) begin
      log_data[log_n] = fdata; log_sel[log_n] = we1;
      log_sum[log_n] = sum; log_cnt[log_n] = cnt;
      log_n++; sum = 0; cnt = 0;
    end
    conv_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        conv_data = 12'($urandom);
        conv_valid = 1'b1;
        sum += int'(conv_data); cnt++;
        last_valid = cyc;
      end
    end
    if (conv_req) begin
      pend = 13;
      if (first_req < 0) first_req = cyc;
      if (cnt > 0 && cyc - last_valid < min_gap) min_gap = cyc - last_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic set_step(input int i, input logic [1:0] mode, input logic [2:0] avg,
                          input logic sel, input int open, input int sdly);
    b_avg[i] = avg; b_sel[i] = sel;
    wr(6'(i), (32'(sel) << 26) | (32'(avg) << 2) | 32'(mode));
    wr(6'(16 + i), (32'(sdly) << 24) | 32'(open));
  endtask

  task automatic go();
    log_n = 0; sum = 0; cnt = 0; first_req = -1; min_gap = 1000000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  task automatic check_pass(input logic [15:0] mask, input string r);
    int k = 0;
    for (int i = 0; i < 16; i++) begin
      if (mask[i]) begin
        logic [31:0] exp = (32'(i) << 16) | ((32'(log_sum[k]) >> b_avg[i]) & 32'hfff);
        chk(k < log_n && log_data[k] == exp, {r, " R2 R3 tag/result"}, log_data[k], exp);
        chk(k < log_n && log_cnt[k] == (1 << b_avg[i]), "R3 sample count", log_cnt[k], 1 << b_avg[i]);
        chk(k < log_n && log_sel[k] == b_sel[i], "R5 FIFO routing", 32'(log_sel[k]), 32'(b_sel[i]));
        k++;
      end
    end
    chk(log_n == k, {r, " R2 push count"}, log_n, k);
  endtask

  initial begin
    logic [15:0] m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && eos == 0 && ovr == 0 && step_en == 0 && !we0 && !we1 && !conv_req,
        "R1 reset", {busy, eos, ovr, step_en}, 32'd0);
    rst_n = 1'b1;

    // R10 empty mask start ignored
    go(); repeat (4) @(negedge clk);
    chk(busy == 0 && eos == 0, "R10 empty start", {busy, eos}, 32'd0);

    // R11 step writes leave mask alone
    set_step(1, 2'd0, 3'd2, 1'b0, 3, 1);
    set_step(4, 2'd0, 3'd0, 1'b1, 0, 0);
    set_step(15, 2'd0, 3'd1, 1'b1, 5, 2);
    chk(step_en == 0, "R11 mask unchanged", step_en, 32'd0);
    wr(6'd32, 32'h8012);
    chk(step_en == 16'h8012, "R11 mask write", step_en, 32'h8012);
    go();
    @(negedge clk);
    chk(busy == 1, "R8 busy after start", busy, 1);
    wait_idle();
    check_pass(16'h8012, "directed");
    chk(step_en == 0, "R6 one-shot clears", step_en, 32'd0);
    chk(eos == 1, "R8 eos set", eos, 1);
    wr(6'd33, 32'd1);
    chk(eos == 0, "R11 eos W1C", eos, 0);

    // R2 R3 random passes
    for (int r = 0; r < 6; r++) begin
      m = 16'($urandom) | 16'h8001;
      for (int i = 0; i < 16; i++)
        if (m[i]) set_step(i, 2'd0, 3'($urandom % 3), 1'($urandom), $urandom % 8, $urandom % 4);
      wr(6'd32, 32'(m));
      go(); wait_idle();
      check_pass(m, "random");
      chk(step_en == 0, "R6 one-shot clears random", step_en, 0);
    end

    // R4 delays
    set_step(0, 2'd0, 3'd1, 1'b0, 40, 10);
    wr(6'd32, 32'h1);
    go(); wait_idle();
    chk(first_req - cyc + cyc >= 0 && log_n == 1 && log_cnt[0] == 2, "R4 one result", log_n, 1);
    chk(min_gap >= 10, "R4 sample gap", min_gap, 10);

    // R6 continuous
    set_step(2, 2'd1, 3'd0, 1'b0, 2, 1);
    wr(6'd32, 32'h4);
    go();
    for (int k = 0; k < 2000 && log_n < 3; k++) @(negedge clk);
    chk(log_n >= 3 && step_en[2] == 1, "R6 continuous repeats", log_n, 3);
    chk(eos == 1 && busy == 1, "R8 eos while running", {eos, busy}, 3);
    wr(6'd32, 32'h0);
    wait_idle();
    chk(busy == 0 && log_data[2][19:16] == 4'd2, "R6 continuous stops", busy, 0);

    // R7 trigger-held step
    set_step(3, 2'd2, 3'd0, 1'b1, 1, 1);
    wr(6'd32, 32'h8);
    go();
    repeat (60) @(negedge clk);
    chk(log_n == 0 && busy == 1, "R7 waits for trigger", log_n, 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    for (int k = 0; k < 500 && log_n < 1; k++) @(negedge clk);
    chk(log_n == 1 && log_sel[0] == 1 && log_data[0][19:16] == 4'd3, "R7 triggered step", log_data[0], 32'h30000);
    chk(step_en[3] == 1, "R7 step stays enabled", step_en, 32'h8);
    wr(6'd32, 32'h0);
    repeat (5) @(negedge clk);
    chk(busy == 0 && log_n == 1, "R7 release on disable", busy, 0);

    // R9 overrun
    wr(6'd33, 32'h7);
    set_step(5, 2'd0, 3'd0, 1'b1, 0, 0);
    set_step(6, 2'd0, 3'd0, 1'b0, 0, 0);
    full1 = 1'b1;
    wr(6'd32, 32'h60);
    go(); wait_idle();
    chk(log_n == 1 && log_sel[0] == 0, "R9 full drop", log_n, 1);
    chk(ovr == 2'b10, "R9 overrun flag", ovr, 2);
    chk(step_en == 0, "R6 dropped step cleared", step_en, 0);
    full1 = 1'b0;
    wr(6'd33, 32'h4);
    chk(ovr == 2'b00, "R9 overrun W1C", ovr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule